// File: doc/BRIEF.md
# Registered Two-Level Lookahead Adder

This block adds two unsigned 64-bit operands and presents a 64-bit sum together with the carry out of the top bit. It does not pass a carry from bit to bit down the word. Each bit column produces a generate term and a propagate term. Four-bit groups merge these terms into group-level generate and propagate signals. A second-level lookahead unit then works out the carry into each of four groups, and together they form a 16-bit section. Four sections are chained, and each section's carry out is the carry in of the section above it. No carry enters bit 0.

The adder sits between two register stages. On every rising clock edge the two operands are captured into operand registers, and the sum and carry computed from the previously captured operands are captured into result registers. A new operand pair can be applied on every cycle. Its result appears after the second rising edge. The active-high reset is asynchronous and clears all four registers to zero as soon as it is raised.

Top module: `reg_cla_adder64`

## Requirements
- R1: After a pair of operands has been applied for one rising edge, `sum_q` equals the low 64 bits of `op_a + op_b` after the following rising edge, which is two edges after presentation.
- R2: `carry_q` equals bit 64 of the 65-bit sum of the same operand pair, with the same latency as R1, so it can be 1 only if bit 63 of at least one operand is 1.
- R3: The carry into bit 0 is zero. Adding zero to zero gives a zero sum and a zero carry, never 1.
- R4: While `rst` is 1, `sum_q` and `carry_q` are 0. They clear at the moment `rst` rises, without waiting for a clock edge.
- R5: Reset also clears the operand registers. The first rising edge after `rst` falls therefore loads a zero result, whatever values are on `op_a` and `op_b`.
- R6: A carry that must travel across any 4-bit group boundary is resolved correctly. For every k from 1 to 15, adding (2^(4k) − 1) and 1 gives 2^(4k).
- R7: A carry that must travel across the 16-bit section boundaries (bits 16, 32 and 48) and out of bit 63 is resolved correctly. All-ones plus one gives a sum of 0 and a carry of 1.
- R8: Operand pairs applied on consecutive cycles produce their results on consecutive cycles, in order and without interference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all registers |
| rst | input | 1 | Asynchronous clear, active high |
| op_a | input | 64 | First operand, unsigned |
| op_b | input | 64 | Second operand, unsigned |
| sum_q | output | 64 | Registered low 64 bits of the sum |
| carry_q | output | 1 | Registered carry out of bit 63 |

## Verification
Zero plus zero shows whether a stray carry enters bit 0. Complementary alternating patterns give an all-ones sum with no carry at all, while doubling one alternating pattern makes a carry in every other column. These separate the generate path from the propagate path. A run of ones plus one, widened four bits at a time, forces a carry to cross each group boundary in turn, and the widths that reach bits 16, 32, 48 and 64 exercise the second-level unit and the section chain. Random operands applied back to back cover mixed cases and show that the pipeline keeps results in order. A reset raised mid-stream is checked before any clock edge, and the first result after release is checked to be zero.

// File: rtl/cla_pkg.sv
package cla_pkg;
    localparam int unsigned CLA_DATA_W  = 64;
    localparam int unsigned CLA_GROUP_W = 4;
    localparam int unsigned CLA_GROUPS  = 4;
    localparam logic        CLA_CARRY_IN = 1'b0;
endpackage

// File: rtl/cla_lookahead.sv
// Generic lookahead unit: carries into each position in sum-of-products form,
// plus block generate / propagate for the next level up.
module cla_lookahead #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] g,
    input  logic [N-1:0] p,
    input  logic         cin,
    output logic [N-1:0] c_pos,
    output logic         blk_g,
    output logic         blk_p
);
    always_comb begin
        logic prod;
        logic acc;
        c_pos    = '0;
        c_pos[0] = cin;
        for (int i = 1; i < N; i++) begin
            acc = 1'b0;
            for (int j = 0; j < i; j++) begin
                prod = g[j];
                for (int k = j + 1; k < i; k++) prod = prod & p[k];
                acc = acc | prod;
            end
            prod = cin;
            for (int k = 0; k < i; k++) prod = prod & p[k];
            c_pos[i] = acc | prod;
        end
        acc = 1'b0;
        for (int j = 0; j < N; j++) begin
            prod = g[j];
            for (int k = j + 1; k < N; k++) prod = prod & p[k];
            acc = acc | prod;
        end
        blk_g = acc;
        blk_p = &p;
    end
endmodule

// File: rtl/cla_group.sv
// One lookahead group: column terms, internal carries, sum bits.
module cla_group #(
    parameter int unsigned GW = 4
) (
    input  logic [GW-1:0] a,
    input  logic [GW-1:0] b,
    input  logic          cin,
    output logic [GW-1:0] sum,
    output logic          grp_g,
    output logic          grp_p
);
    logic [GW-1:0] col_g;
    logic [GW-1:0] col_p;
    logic [GW-1:0] col_c;

    assign col_g = a & b;
    assign col_p = a | b;

    cla_lookahead #(.N(GW)) u_la (
        .g     (col_g),
        .p     (col_p),
        .cin   (cin),
        .c_pos (col_c),
        .blk_g (grp_g),
        .blk_p (grp_p)
    );

    assign sum = a ^ b ^ col_c;
endmodule

// File: rtl/cla_section.sv
// Section of NG groups joined by a second-level lookahead unit.
module cla_section #(
    parameter int unsigned GW = 4,
    parameter int unsigned NG = 4,
    localparam int unsigned SW = GW * NG
) (
    input  logic [SW-1:0] a,
    input  logic [SW-1:0] b,
    input  logic          cin,
    output logic [SW-1:0] sum,
    output logic          cout
);
    logic [NG-1:0] grp_g;
    logic [NG-1:0] grp_p;
    logic [NG-1:0] grp_c;
    logic          sec_g;
    logic          sec_p;

    for (genvar gi = 0; gi < NG; gi++) begin : g_grp
        cla_group #(.GW(GW)) u_grp (
            .a     (a[gi*GW +: GW]),
            .b     (b[gi*GW +: GW]),
            .cin   (grp_c[gi]),
            .sum   (sum[gi*GW +: GW]),
            .grp_g (grp_g[gi]),
            .grp_p (grp_p[gi])
        );
    end

    cla_lookahead #(.N(NG)) u_lvl2 (
        .g     (grp_g),
        .p     (grp_p),
        .cin   (cin),
        .c_pos (grp_c),
        .blk_g (sec_g),
        .blk_p (sec_p)
    );

    assign cout = sec_g | (sec_p & cin);
endmodule

// File: rtl/reg_cla_adder64.sv
// Register-in / register-out adder built from chained lookahead sections.
module reg_cla_adder64
    import cla_pkg::*;
#(
    parameter int unsigned WIDTH  = CLA_DATA_W,
    parameter int unsigned GW     = CLA_GROUP_W,
    parameter int unsigned NG     = CLA_GROUPS,
    localparam int unsigned SEC_W = GW * NG,
    localparam int unsigned N_SEC = WIDTH / SEC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] sum_q,
    output logic             carry_q
);
    logic [WIDTH-1:0] a_q;
    logic [WIDTH-1:0] b_q;
    logic [WIDTH-1:0] sum_d;
    logic [N_SEC:0]   sec_c;

    assign sec_c[0] = CLA_CARRY_IN;

    for (genvar si = 0; si < N_SEC; si++) begin : g_sec
        cla_section #(.GW(GW), .NG(NG)) u_sec (
            .a    (a_q[si*SEC_W +: SEC_W]),
            .b    (b_q[si*SEC_W +: SEC_W]),
            .cin  (sec_c[si]),
            .sum  (sum_d[si*SEC_W +: SEC_W]),
            .cout (sec_c[si+1])
        );
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            a_q     <= '0;
            b_q     <= '0;
            sum_q   <= '0;
            carry_q <= 1'b0;
        end else begin
            a_q     <= op_a;
            b_q     <= op_b;
            sum_q   <= sum_d;
            carry_q <= sec_c[N_SEC];
        end
    end
endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk #(
    parameter int unsigned W = 64
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [W-1:0] sum_q,
    input logic         carry_q
);
    // edges seen since reset release, saturating at 2
    logic [1:0] warm;
    always_ff @(posedge clk or posedge rst) begin
        if (rst) warm <= 2'd0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    assert_sum_value_R1: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd2) |-> (sum_q == W'($past(op_a, 2) + $past(op_b, 2))));

    assert_carry_value_R2: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd2) |-> (carry_q == (W'($past(op_a, 2) + $past(op_b, 2)) < $past(op_a, 2))));

    assert_carry_needs_msb_R2: assert property (@(posedge clk) disable iff (rst)
        ((warm == 2'd2) && carry_q) |-> $past(op_a[W-1] | op_b[W-1], 2));

    assert_first_after_reset_R5: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd1) |-> (sum_q == '0 && !carry_q));

    always @(negedge clk) begin
        if (rst) begin
            assert_reset_clear_R4: assert (sum_q == '0 && !carry_q);
        end
    end
endmodule

bind reg_cla_adder64 cla_adder_chk #(.W(WIDTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .op_a    (op_a),
    .op_b    (op_b),
    .sum_q   (sum_q),
    .carry_q (carry_q)
);

// File: tb/sim_reg_cla_adder64.sv
module sim_reg_cla_adder64;
    logic        clk;
    logic        rst;
    logic [63:0] op_a;
    logic [63:0] op_b;
    logic [63:0] sum_q;
    logic        carry_q;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    logic [64:0] exp_q[$];
    int          due_q[$];
    string       tag_q[$];

    reg_cla_adder64 u0 (
        .clk     (clk),
        .rst     (rst),
        .op_a    (op_a),
        .op_b    (op_b),
        .sum_q   (sum_q),
        .carry_q (carry_q)
    );

    initial begin
        clk = 1'b0;
        forever #10 clk = ~clk;
    end

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [64:0] act, input logic [64:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // driver: apply operands, push expected result and the cycle it is due
    task automatic drive(input logic [63:0] a, input logic [63:0] b, input string req);
        @(negedge clk);
        #1;
        op_a = a;
        op_b = b;
        exp_q.push_back({1'b0, a} + {1'b0, b});
        due_q.push_back(cyc + 2);
        tag_q.push_back(req);
    endtask

    // monitor: compare when the front item falls due
    always @(negedge clk) begin
        if (!rst && due_q.size() > 0 && due_q[0] == cyc) begin
            check(tag_q[0], {carry_q, sum_q}, exp_q[0]);
            void'(exp_q.pop_front());
            void'(due_q.pop_front());
            void'(tag_q.pop_front());
        end
    end

    task automatic drain();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #4_000_000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        rst  = 1'b1;
        op_a = 64'hFFFF_FFFF_FFFF_FFFF;
        op_b = 64'h1;
        #5;
        check("R4 reset state", {carry_q, sum_q}, 65'd0);
        repeat (2) @(negedge clk);
        #2 rst = 1'b0;

        drive(64'd0, 64'd0, "R3 zero plus zero");
        drive(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, "R7 all ones plus one");
        drive(64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, "R8 alt complement");
        drive(64'hAAAA_AAAA_AAAA_AAAA, 64'hAAAA_AAAA_AAAA_AAAA, "R8 alt doubled");
        drive(64'h5555_5555_5555_5555, 64'h5555_5555_5555_5555, "R8 alt doubled low");
        drive(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R2 max plus max");
        for (int k = 1; k < 16; k++) begin
            drive((64'h1 << (4 * k)) - 64'h1, 64'd1, (k % 4 == 0) ? "R7 section cross" : "R6 group cross");
        end
        drive(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, "R2 msb carry only");
        drive(64'h0000_0000_FFFF_0000, 64'h0000_0000_0001_0000, "R7 mid section");
        for (int n = 0; n < 40; n++) begin
            drive({$urandom, $urandom}, {$urandom, $urandom}, "R1 random");
        end
        drive(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R2 before reset");
        drain();

        // mid-stream asynchronous reset: cleared before any edge
        check("R4 outputs before reset", {carry_q, sum_q}, 65'h1_FFFF_FFFF_FFFF_FFFE);
        @(negedge clk);
        #5 rst = 1'b1;
        #1 check("R4 async clear", {carry_q, sum_q}, 65'd0);
        exp_q.delete();
        due_q.delete();
        tag_q.delete();
        @(negedge clk);
        #5 rst = 1'b0;
        @(negedge clk);
        check("R5 first result after release", {carry_q, sum_q}, 65'd0);
        @(negedge clk);
        check("R1 held operands after release", {carry_q, sum_q}, 65'h1_FFFF_FFFF_FFFF_FFFE);

        drive(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, "R1 after reset");
        drive(64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, "R7 two sections");
        drain();
        total++;
        if (due_q.size() != 0) begin
            bad++;
            $display("FAIL R8: actual=%0d pending expected=0", due_q.size());
        end
        summary();
    end
endmodule